// File: doc/BRIEF.md
# Dual-Bank Line Capture Steering Controller

This block sits between a line-scan camera's pixel stream and a pair of line memories of `BANK_DEPTH` words each. One bank is the capture bank and receives the current line. The other bank holds the previous line and is lent to a downstream processor, such as a spectral transform engine. A one-bit flag selects which bank is being filled. The two banks change roles only when both jobs are finished: the camera must have closed its line by dropping line-valid, and the processor must have reported completion with a done pulse.

Incoming words first pass through a small synchronous FIFO. The FIFO keeps the camera-side timing apart from the memory write timing. It also holds words that arrive for the next line while the controller is still waiting for the processor to release the other bank. The falling edge of line-valid travels through the same FIFO as an end-of-line marker, so the line boundary stays in order with the data.

The controller has three states. In `ST_CAPTURE` it pops the FIFO and writes data words to the capture bank. When it pops an end-of-line marker it goes to `ST_HOLD`. In `ST_HOLD` it stops popping; once the processor is idle it goes to `ST_SWAP`. `ST_SWAP` lasts one cycle: it flips the bank flag, rewinds the address counter, marks the just-filled bank as ready for processing, and returns to `ST_CAPTURE`.

Top module: `pingpong_line_ctrl`

## Requirements
- R1: After reset, bank 0 is the capture bank (`wr_bank`=0), `frame_ready`=0, `wr_en`=0, `line_trunc`=0 and `fifo_overrun`=0.
- R2: A word is accepted only in a cycle where `pix_valid` and `line_valid` are both 1. Accepted words are written to the capture bank in arrival order, at addresses 0, 1, 2, and so on. A `pix_valid` pulse while `line_valid` is 0 produces no write.
- R3: A falling edge of `line_valid` ends the line. If the processor is idle, the banks then swap. After the swap, `frame_ready`=1, `ready_bank` equals the bank that was just filled, and `wr_bank` equals the other bank.
- R4: While `frame_ready`=1, a completed line does not cause a swap. The controller waits in `ST_HOLD` and makes no writes. Words of the next line stay in the FIFO and are written to the new capture bank, starting at address 0, after `proc_done` releases the swap.
- R5: The write address stops at `BANK_DEPTH`-1. Words beyond `BANK_DEPTH` in one line are dropped and set `line_trunc`. `line_trunc` stays set until the next swap clears it.
- R6: A word that arrives while the FIFO holds `FIFO_DEPTH` entries is dropped and sets `fifo_overrun`. `fifo_overrun` stays set until reset.
- R7: A `proc_done` pulse while `frame_ready`=0 has no effect.
- R8: `proc_done` sampled while `frame_ready`=1 clears `frame_ready` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | DATA_W | Pixel word |
| pix_valid | input | 1 | Pixel word strobe |
| line_valid | input | 1 | High for the duration of a line |
| proc_done | input | 1 | Processor has finished with the ready bank |
| wr_en | output | 1 | Write strobe to the capture bank |
| wr_bank | output | 1 | Index of the capture bank |
| wr_addr | output | ADDR_W | Write address in the capture bank |
| wr_data | output | DATA_W | Write data |
| frame_ready | output | 1 | A filled bank is lent to the processor |
| ready_bank | output | 1 | Index of the bank to be read by the processor |
| line_trunc | output | 1 | The current line exceeded the bank size |
| fifo_overrun | output | 1 | Sticky: a word was lost because the FIFO was full |

## Verification
The assertions take the following for granted about the inputs:
- `proc_done` is a short pulse and is only meaningful while a bank is lent out.
- `line_valid` changes on clock edges like any other synchronous input.
- Pixel words are qualified by `line_valid`.

The stimulus drives every input at the falling clock edge, in single-cycle steps. It pulses `proc_done` for exactly one cycle, including one deliberate stray pulse while idle. Overflow is provoked on purpose in two ways. First, a line of 1027 words is sent against a 1024-word bank. Second, twelve words are sent into an 8-deep FIFO while the controller is held in `ST_HOLD`.

// File: rtl/pp_line_pkg.sv
package pp_line_pkg;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_HOLD    = 2'd1,
        ST_SWAP    = 2'd2
    } cap_state_e;

endpackage

// File: rtl/pp_line_ingress.sv
module pp_line_ingress #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    input  logic              line_valid,
    output logic              push,
    output logic [DATA_W:0]   push_entry
);
    logic lv_q;
    logic line_end;

    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= line_valid;
    end

    assign line_end   = lv_q && !line_valid;
    assign push       = (pix_valid && line_valid) || line_end;
    assign push_entry = {line_end, (line_end ? '0 : pix_data)};

    // R2: pixel strobes outside a line never become data entries
    assert_no_stray_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !push_entry[DATA_W]) |-> line_valid);
endmodule

// File: rtl/pp_line_fifo.sv
module pp_line_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_entry,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, accept, take;

    assign full   = (count == CNT_FULL);
    assign empty  = (count == '0);
    assign accept = push && !full;
    assign take   = pop && !empty;
    assign head   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (take)   rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(accept) - CNT_W'(take);
            if (push && full) overrun <= 1'b1;
        end
    end

    // R6: a push into a full FIFO with no pop leaves it full
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    // R6: the overrun flag never clears without reset
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);
endmodule

// File: rtl/pp_line_fsm.sv
module pp_line_fsm
    import pp_line_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int BANK_DEPTH = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_empty,
    input  logic [DATA_W:0]               fifo_head,
    input  logic                          proc_done,
    output logic                          fifo_pop,
    output logic                          wr_en,
    output logic                          wr_bank,
    output logic [$clog2(BANK_DEPTH)-1:0] wr_addr,
    output logic [DATA_W-1:0]             wr_data,
    output logic                          frame_ready,
    output logic                          ready_bank,
    output logic                          line_trunc
);
    localparam int ADDR_W = $clog2(BANK_DEPTH);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(BANK_DEPTH - 1);

    cap_state_e        state, state_nx;
    logic              cap_bank;
    logic              proc_busy;
    logic              bank_full;
    logic [ADDR_W-1:0] addr_cnt;
    logic              head_last;

    assign head_last = fifo_head[DATA_W];
    assign fifo_pop  = (state == ST_CAPTURE) && !fifo_empty;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CAPTURE: if (fifo_pop && head_last) state_nx = ST_HOLD;
            ST_HOLD:    if (!proc_busy)            state_nx = ST_SWAP;
            ST_SWAP:                               state_nx = ST_CAPTURE;
            default:                               state_nx = ST_CAPTURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CAPTURE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bank   <= 1'b0;
            proc_busy  <= 1'b0;
            bank_full  <= 1'b0;
            addr_cnt   <= '0;
            line_trunc <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (fifo_pop && !head_last) begin
                if (!bank_full) begin
                    wr_en   <= 1'b1;
                    wr_addr <= addr_cnt;
                    wr_data <= fifo_head[DATA_W-1:0];
                    if (addr_cnt == ADDR_LAST) bank_full <= 1'b1;
                    else                       addr_cnt  <= addr_cnt + 1'b1;
                end else begin
                    line_trunc <= 1'b1;
                end
            end
            if (state == ST_SWAP) begin
                cap_bank   <= ~cap_bank;
                addr_cnt   <= '0;
                bank_full  <= 1'b0;
                line_trunc <= 1'b0;
                proc_busy  <= 1'b1;
            end else if (proc_busy && proc_done) begin
                proc_busy <= 1'b0;
            end
        end
    end

    assign wr_bank     = cap_bank;
    assign frame_ready = proc_busy;
    assign ready_bank  = ~cap_bank;

    // R4: writes only follow a capture-state cycle
    assert_write_in_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(state) == ST_CAPTURE));
    // R4: a busy processor keeps the controller holding
    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && proc_busy) |=> (state == ST_HOLD));
    // R3: every swap flips the capture bank and lends out the filled one
    assert_swap_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |=> (cap_bank != $past(cap_bank) && frame_ready));
    // R8: done while lent clears readiness at the next edge
    assert_done_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_busy && proc_done && state != ST_SWAP) |=> !frame_ready);
    // R7: readiness never rises outside a swap
    assert_no_spurious_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_ready) |-> ($past(state) == ST_SWAP));
    // R5: truncation flag holds until a swap
    assert_trunc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_trunc && state != ST_SWAP) |=> line_trunc);
endmodule

// File: rtl/pingpong_line_ctrl.sv
module pingpong_line_ctrl #(
    parameter int DATA_W     = 16,
    parameter int BANK_DEPTH = 1024,
    parameter int FIFO_DEPTH = 8,
    localparam int ADDR_W    = $clog2(BANK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pix_data,
    input  logic              pix_valid,
    input  logic              line_valid,
    input  logic              proc_done,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_ready,
    output logic              ready_bank,
    output logic              line_trunc,
    output logic              fifo_overrun
);
    localparam int ENTRY_W = DATA_W + 1;

    logic               push, pop, empty;
    logic [ENTRY_W-1:0] push_entry, head;

    pp_line_ingress #(.DATA_W(DATA_W)) u_ingress (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_data   (pix_data),
        .pix_valid  (pix_valid),
        .line_valid (line_valid),
        .push       (push),
        .push_entry (push_entry)
    );

    pp_line_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .overrun    (fifo_overrun)
    );

    pp_line_fsm #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_empty  (empty),
        .fifo_head   (head),
        .proc_done   (proc_done),
        .fifo_pop    (pop),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_ready (frame_ready),
        .ready_bank  (ready_bank),
        .line_trunc  (line_trunc)
    );
endmodule

// File: tb/test_pingpong_line_ctrl.sv
module test_pingpong_line_ctrl;
    localparam int DATA_W     = 16;
    localparam int BANK_DEPTH = 1024;
    localparam int FIFO_DEPTH = 8;
    localparam int ADDR_W     = $clog2(BANK_DEPTH);
    localparam int ITEM_W     = 1 + ADDR_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] pix_data = '0;
    logic              pix_valid = 1'b0;
    logic              line_valid = 1'b0;
    logic              proc_done = 1'b0;
    logic              wr_en, wr_bank, frame_ready, ready_bank, line_trunc, fifo_overrun;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [ITEM_W-1:0] sb_q [$];

    always #2.5 clk = ~clk;

    pingpong_line_ctrl #(.DATA_W(DATA_W), .BANK_DEPTH(BANK_DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) i_pingpong_line_ctrl (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
        .line_valid(line_valid), .proc_done(proc_done), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .frame_ready(frame_ready),
        .ready_bank(ready_bank), .line_trunc(line_trunc), .fifo_overrun(fifo_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: every write must match the next expected item
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2/R4: unexpected write actual %0h expected none",
                         {wr_bank, wr_addr, wr_data});
            end else begin
                chk("R2 write item", {wr_bank, wr_addr, wr_data}, sb_q.pop_front());
            end
        end
    end

    task automatic send_word(input logic [DATA_W-1:0] d, input logic bank,
                             input int addr, input bit expect_wr);
        @(negedge clk);
        pix_data   = d;
        pix_valid  = 1'b1;
        line_valid = 1'b1;
        if (expect_wr) sb_q.push_back({bank, ADDR_W'(addr), d});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b0;
        end
    endtask

    task automatic end_line();
        @(negedge clk);
        pix_valid  = 1'b0;
        line_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        proc_done = 1'b1;
        @(negedge clk);
        proc_done = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 frame_ready", frame_ready, 0);
        chk("R1 wr_bank", wr_bank, 0);
        chk("R1 wr_en", wr_en, 0);
        chk("R1 line_trunc", line_trunc, 0);
        chk("R1 fifo_overrun", fifo_overrun, 0);

        // R2 stray strobe outside a line: no write expected
        @(negedge clk);
        pix_data = 16'hDEAD; pix_valid = 1'b1;
        idle(4);

        // Line A -> bank 0, with gaps
        for (int i = 0; i < 10; i++) begin
            send_word(16'h1000 + 16'(i), 1'b0, i, 1'b1);
            if (i % 3 == 2) idle(2);
        end
        end_line();
        idle(6);
        chk("R3 frame_ready after line A", frame_ready, 1);
        chk("R3 ready_bank", ready_bank, 0);
        chk("R3 wr_bank", wr_bank, 1);
        chk("R2 all A writes done", sb_q.size(), 0);

        // Line B -> bank 1; processor still busy with A
        for (int i = 0; i < 6; i++) send_word(16'h2000 + 16'(i), 1'b1, i, 1'b1);
        end_line();
        idle(6);
        chk("R4 still lent", frame_ready, 1);
        chk("R4 ready_bank held", ready_bank, 0);
        // Line C words wait in the FIFO
        for (int i = 0; i < 5; i++) send_word(16'h3000 + 16'(i), 1'b0, i, 1'b1);
        idle(5);
        chk("R4 no writes while holding", sb_q.size(), 5);
        @(negedge clk);
        proc_done = 1'b1;
        @(negedge clk);
        proc_done = 1'b0;
        chk("R8 ready cleared after done", frame_ready, 0);
        idle(3);
        chk("R3 ready after swap", frame_ready, 1);
        chk("R3 ready_bank B", ready_bank, 1);
        chk("R3 wr_bank C", wr_bank, 0);
        idle(10);
        chk("R4 held words drained", sb_q.size(), 0);
        end_line();
        idle(3);
        pulse_done();   // release B, C becomes ready
        idle(4);
        chk("R3 ready_bank C", ready_bank, 0);
        pulse_done();   // release C
        idle(2);
        chk("R8 idle", frame_ready, 0);
        // R7 stray done while idle
        pulse_done();
        idle(3);
        chk("R7 stray done ignored", frame_ready, 0);
        chk("R7 wr_bank unchanged", wr_bank, 1);

        // Line D -> bank 1, oversize
        for (int i = 0; i < BANK_DEPTH + 3; i++)
            send_word(16'(i * 7 + 3), 1'b1, i, i < BANK_DEPTH);
        idle(5);
        chk("R5 trunc set", line_trunc, 1);
        chk("R5 writes capped", sb_q.size(), 0);
        chk("R6 no overrun yet", fifo_overrun, 0);
        end_line();
        idle(6);
        chk("R5 trunc cleared by swap", line_trunc, 0);
        chk("R3 ready_bank D", ready_bank, 1);

        // Line E -> bank 0, then hold (D still lent)
        for (int i = 0; i < 3; i++) send_word(16'h5000 + 16'(i), 1'b0, i, 1'b1);
        end_line();
        idle(6);
        // Line F: 12 words into an 8-deep FIFO
        for (int i = 0; i < 12; i++)
            send_word(16'h6000 + 16'(i), 1'b1, i, i < FIFO_DEPTH);
        idle(2);
        chk("R6 overrun set", fifo_overrun, 1);
        pulse_done();
        idle(16);
        chk("R6 kept words written", sb_q.size(), 0);
        chk("R6 overrun sticky", fifo_overrun, 1);
        chk("R3 wr_bank F", wr_bank, 1);
        end_line();
        idle(4);
        summary();
    end
endmodule